// File: doc/BRIEF.md
# Single-Cycle 16-bit CPU Core

This core runs a compact sixteen-opcode instruction set. Every instruction finishes in one clock. The core drives an 8-bit instruction address and receives the 16-bit instruction word from program memory outside the core in the same cycle. Inside the core, a field decoder feeds three parts:

- a sixteen-entry, 16-bit register file with two combinational read ports;
- an ALU that keeps a zero flag;
- a program counter that can jump to an absolute address or branch relative to the current address.

There are four instruction formats:

- **Three-register:** opcode, destination, source A, source B.
- **Register plus small constant:** the last nibble is a 4-bit constant.
- **Load constant:** an 8-bit constant is written to the destination.
- **Branch:** an 8-bit target or offset.

Both constants are zero-extended to 16 bits. The compare instruction subtracts and sets the flag, but writes no register. The conditional branches test that flag.

Debug outputs expose the current instruction, both register read values, the ALU result, the PC and the chosen second ALU operand. A bench or a trace unit can follow execution cycle by cycle from these outputs.

Top module: `cpu16_core`

## Requirements
- R1: `rst_ni` low asynchronously clears the PC, all sixteen registers and the zero flag. After release, execution starts at address 0.
- R2: Fields of `imem_data_i`:
  - [15:12] is the opcode.
  - [11:8] is the destination.
  - [7:4] selects the register shown on `dbg_rd_a_o`.
  - [3:0] selects the register shown on `dbg_rd_b_o`.
  - Both read ports are combinational.
- R3: Register operations, where the result is A op B and is written to the destination at the clock edge:
  - opcode 0 is AND;
  - opcode 1 is OR;
  - opcode 2 is ADD;
  - opcode 3 is SUB (A minus B);
  - opcode 4 is XOR;
  - opcode 5 is logical shift right of A by B;
  - opcode 6 is logical shift left of A by B.
  - A shift amount of 16 or more gives 0.
- R4: Constant operations, with the second operand shown on `dbg_op_b_o`:
  - opcode 7 writes the zero-extended [7:0] to the destination;
  - opcodes 8, 9 and 10 compute A AND, OR and ADD the zero-extended [3:0].
- R5: Opcodes 0 to 10 write the ALU result to the destination register. Opcodes 11 to 15 leave every register unchanged.
- R6: The zero flag is set to (result == 0) only by opcodes 2, 3, 10 and 11. Opcode 11 computes A minus B. Every other opcode holds the flag.
- R7: Opcode 13 loads the PC with [7:0].
- R8: The next PC depends on the opcode:
  - opcode 14 branches to PC + [7:0] (modulo 256) when the zero flag is 0;
  - opcode 15 branches to PC + [7:0] (modulo 256) when the zero flag is 1;
  - in every other case the PC advances by 1, modulo 256.
- R9: `dbg_alu_o` shows the ALU result and is 0 for opcodes 12 to 15. For branch opcodes `dbg_op_b_o` shows the zero-extended [7:0]. For opcodes 0 to 6, 11 and 12 it shows the B register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 8 | Instruction address (current PC) |
| imem_data_i | input | 16 | Instruction word at `imem_addr_o` |
| dbg_instr_o | output | 16 | Instruction being executed |
| dbg_rd_a_o | output | 16 | Register read port A value |
| dbg_rd_b_o | output | 16 | Register read port B value |
| dbg_alu_o | output | 16 | ALU result |
| dbg_pc_o | output | 8 | Program counter |
| dbg_op_b_o | output | 16 | Selected second ALU operand |

## Verification
The bound checker checks these rules on every cycle:
- sequential PC advance for non-branch opcodes;
- the absolute jump target;
- that the zero flag holds unless a flag-updating opcode ran;
- that a flag update matches the previous result;
- zero-extension of the 4-bit constant;
- a zero ALU output for idle and branch opcodes.

Only the bench's program can show the rest:
- register contents after a sequence of writes;
- that compare and branches do not write;
- whether each conditional branch is taken or not;
- the PC wrap on a relative branch;
- that asynchronous reset clears registers and the flag.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  typedef enum logic [3:0] {
    OP_AND, OP_OR, OP_ADD, OP_SUB, OP_XOR, OP_SHR, OP_SHL, OP_LDI,
    OP_ANDI, OP_ORI, OP_ADDI, OP_CMP, OP_NOP, OP_JMP, OP_BNE, OP_BEQ
  } opc_e;

  typedef enum logic [2:0] {
    FN_AND, FN_OR, FN_ADD, FN_SUB, FN_XOR, FN_SHR, FN_SHL, FN_PASSB
  } alu_fn_e;

  typedef enum logic [1:0] {OPB_REG, OPB_IMM4, OPB_IMM8} opb_sel_e;

  typedef enum logic [1:0] {BR_NONE, BR_ABS, BR_NE, BR_EQ} br_e;

  typedef struct packed {
    alu_fn_e  fn;
    logic     alu_en;
    logic     flag_upd;
    logic     wr_en;
    opb_sel_e opb_sel;
    br_e      br;
  } ctrl_t;

endpackage

// File: rtl/cpu16_decoder.sv
module cpu16_decoder
  import cpu16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic [15:0]       instr_i,
  output ctrl_t             ctrl_o,
  output logic [IDX_W-1:0]  rd_o,
  output logic [IDX_W-1:0]  rs_a_o,
  output logic [IDX_W-1:0]  rs_b_o,
  output logic [DATA_W-1:0] imm4_o,
  output logic [DATA_W-1:0] imm8_o
);

  opc_e opc;
  assign opc    = opc_e'(instr_i[15:12]);
  assign rd_o   = instr_i[8 +: IDX_W];
  assign rs_a_o = instr_i[4 +: IDX_W];
  assign rs_b_o = instr_i[0 +: IDX_W];
  assign imm4_o = {{(DATA_W-4){1'b0}}, instr_i[3:0]};
  assign imm8_o = {{(DATA_W-8){1'b0}}, instr_i[7:0]};

  always_comb begin
    ctrl_o = '{fn: FN_AND, alu_en: 1'b1, flag_upd: 1'b0, wr_en: 1'b1,
               opb_sel: OPB_REG, br: BR_NONE};
    unique case (opc)
      OP_AND:  ctrl_o.fn = FN_AND;
      OP_OR:   ctrl_o.fn = FN_OR;
      OP_ADD:  begin ctrl_o.fn = FN_ADD; ctrl_o.flag_upd = 1'b1; end
      OP_SUB:  begin ctrl_o.fn = FN_SUB; ctrl_o.flag_upd = 1'b1; end
      OP_XOR:  ctrl_o.fn = FN_XOR;
      OP_SHR:  ctrl_o.fn = FN_SHR;
      OP_SHL:  ctrl_o.fn = FN_SHL;
      OP_LDI:  begin ctrl_o.fn = FN_PASSB; ctrl_o.opb_sel = OPB_IMM8; end
      OP_ANDI: begin ctrl_o.fn = FN_AND; ctrl_o.opb_sel = OPB_IMM4; end
      OP_ORI:  begin ctrl_o.fn = FN_OR;  ctrl_o.opb_sel = OPB_IMM4; end
      OP_ADDI: begin
        ctrl_o.fn = FN_ADD; ctrl_o.opb_sel = OPB_IMM4; ctrl_o.flag_upd = 1'b1;
      end
      OP_CMP:  begin
        ctrl_o.fn = FN_SUB; ctrl_o.flag_upd = 1'b1; ctrl_o.wr_en = 1'b0;
      end
      OP_NOP:  begin ctrl_o.alu_en = 1'b0; ctrl_o.wr_en = 1'b0; end
      OP_JMP, OP_BNE, OP_BEQ: begin
        ctrl_o.alu_en  = 1'b0;
        ctrl_o.wr_en   = 1'b0;
        ctrl_o.opb_sel = OPB_IMM8;
        ctrl_o.br      = (opc == OP_JMP) ? BR_ABS :
                         (opc == OP_BNE) ? BR_NE  : BR_EQ;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int DATA_W = 16,
  parameter int REG_N  = 16,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [IDX_W-1:0]  ra_a_i,
  input  logic [IDX_W-1:0]  ra_b_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o
);

  logic [DATA_W-1:0] rows [REG_N];

  for (genvar r = 0; r < REG_N; r++) begin : g_row
    logic              hit;
    logic [DATA_W-1:0] q;
    assign hit = we_i && (wa_i == IDX_W'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= wd_i;
    end
    assign rows[r] = q;
  end

  assign rd_a_o = rows[ra_a_i];
  assign rd_b_o = rows[ra_b_i];

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  alu_fn_e           fn_i,
  input  logic              en_i,
  input  logic              flag_upd_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o
);

  logic              sh_over;
  logic [SH_W-1:0]   sh_amt;
  logic [DATA_W-1:0] res;

  // amounts >= DATA_W shift everything out
  assign sh_over = |b_i[DATA_W-1:SH_W];
  assign sh_amt  = b_i[SH_W-1:0];

  always_comb begin
    unique case (fn_i)
      FN_AND:   res = a_i & b_i;
      FN_OR:    res = a_i | b_i;
      FN_ADD:   res = a_i + b_i;
      FN_SUB:   res = a_i - b_i;
      FN_XOR:   res = a_i ^ b_i;
      FN_SHR:   res = sh_over ? '0 : a_i >> sh_amt;
      FN_SHL:   res = sh_over ? '0 : a_i << sh_amt;
      FN_PASSB: res = b_i;
      default:  res = '0;
    endcase
    if (!en_i) res = '0;
  end

  assign res_o = res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         zero_o <= 1'b0;
    else if (flag_upd_i) zero_o <= (res == '0);
  end

endmodule

// File: rtl/cpu16_pc.sv
module cpu16_pc
  import cpu16_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  br_e               br_i,
  input  logic              zero_i,
  input  logic [ADDR_W-1:0] imm_i,
  output logic [ADDR_W-1:0] pc_o
);

  localparam logic [ADDR_W-1:0] STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] pc_q, pc_d;

  always_comb begin
    unique case (br_i)
      BR_ABS:  pc_d = imm_i;
      BR_NE:   pc_d = !zero_i ? pc_q + imm_i : pc_q + STEP;
      BR_EQ:   pc_d =  zero_i ? pc_q + imm_i : pc_q + STEP;
      default: pc_d = pc_q + STEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int REG_N  = 16,
  localparam int IDX_W = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] imem_addr_o,
  input  logic [15:0]       imem_data_i,
  output logic [15:0]       dbg_instr_o,
  output logic [DATA_W-1:0] dbg_rd_a_o,
  output logic [DATA_W-1:0] dbg_rd_b_o,
  output logic [DATA_W-1:0] dbg_alu_o,
  output logic [ADDR_W-1:0] dbg_pc_o,
  output logic [DATA_W-1:0] dbg_op_b_o
);

  ctrl_t             ctrl;
  logic [IDX_W-1:0]  rd, rs_a, rs_b;
  logic [DATA_W-1:0] imm4, imm8, rd_a, rd_b, op_b, alu_res;
  logic [ADDR_W-1:0] pc;
  logic              zero_flag;

  cpu16_decoder #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
    .instr_i (imem_data_i),
    .ctrl_o  (ctrl),
    .rd_o    (rd),
    .rs_a_o  (rs_a),
    .rs_b_o  (rs_b),
    .imm4_o  (imm4),
    .imm8_o  (imm8)
  );

  cpu16_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl.wr_en),
    .wa_i   (rd),
    .wd_i   (alu_res),
    .ra_a_i (rs_a),
    .ra_b_i (rs_b),
    .rd_a_o (rd_a),
    .rd_b_o (rd_b)
  );

  always_comb begin
    unique case (ctrl.opb_sel)
      OPB_IMM4: op_b = imm4;
      OPB_IMM8: op_b = imm8;
      default:  op_b = rd_b;
    endcase
  end

  cpu16_alu #(.DATA_W(DATA_W)) u_alu (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fn_i       (ctrl.fn),
    .en_i       (ctrl.alu_en),
    .flag_upd_i (ctrl.flag_upd),
    .a_i        (rd_a),
    .b_i        (op_b),
    .res_o      (alu_res),
    .zero_o     (zero_flag)
  );

  cpu16_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .br_i   (ctrl.br),
    .zero_i (zero_flag),
    .imm_i  (imm8[ADDR_W-1:0]),
    .pc_o   (pc)
  );

  assign imem_addr_o = pc;
  assign dbg_instr_o = imem_data_i;
  assign dbg_rd_a_o  = rd_a;
  assign dbg_rd_b_o  = rd_b;
  assign dbg_alu_o   = alu_res;
  assign dbg_pc_o    = pc;
  assign dbg_op_b_o  = op_b;

endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] instr_i,
  input logic [7:0]  pc_i,
  input logic [15:0] alu_i,
  input logic [15:0] opb_i,
  input logic        zf_i
);

  logic [3:0] opc;
  logic       upd;
  assign opc = instr_i[15:12];
  assign upd = (opc == 4'd2) || (opc == 4'd3) || (opc == 4'd10) || (opc == 4'd11);

  assert_pc_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc < 4'd13) |=> (pc_i == $past(pc_i) + 8'd1));

  assert_abs_jump_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc == 4'd13) |=> (pc_i == $past(instr_i[7:0])));

  assert_flag_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> (zf_i == $past(zf_i)));

  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (zf_i == ($past(alu_i) == 16'd0)));

  assert_imm4_ext_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc >= 4'd8 && opc <= 4'd10) |-> (opb_i == {12'd0, instr_i[3:0]}));

  assert_idle_alu_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc >= 4'd12) |-> (alu_i == 16'd0));

endmodule

bind cpu16_core cpu16_core_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .instr_i (imem_data_i),
  .pc_i    (imem_addr_o),
  .alu_i   (dbg_alu_o),
  .opb_i   (dbg_op_b_o),
  .zf_i    (zero_flag)
);

// File: tb/cpu16_core_test.sv
module cpu16_core_test;

  localparam int PERIOD = 10;
  localparam int NSTEP  = 28;

  typedef struct packed {
    logic [7:0]  pc;
    logic [15:0] ins;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] alu;
    logic [15:0] opb;
    logic [3:0]  tag;
  } step_t;

  // program trace: pc, instruction, rd_a, rd_b, alu, op_b, requirement of the alu check
  localparam step_t STEPS [NSTEP] = '{
    '{8'h00, 16'h7105, 16'h0000, 16'h0000, 16'h0005, 16'h0005, 4'd4}, // R4 ldi r1
    '{8'h01, 16'h7203, 16'h0000, 16'h0000, 16'h0003, 16'h0003, 4'd4}, // ldi r2
    '{8'h02, 16'h2312, 16'h0005, 16'h0003, 16'h0008, 16'h0003, 4'd3}, // R3 add
    '{8'h03, 16'h3412, 16'h0005, 16'h0003, 16'h0002, 16'h0003, 4'd3}, // sub
    '{8'h04, 16'h0512, 16'h0005, 16'h0003, 16'h0001, 16'h0003, 4'd3}, // and
    '{8'h05, 16'h1612, 16'h0005, 16'h0003, 16'h0007, 16'h0003, 4'd3}, // or
    '{8'h06, 16'h4712, 16'h0005, 16'h0003, 16'h0006, 16'h0003, 4'd3}, // xor
    '{8'h07, 16'h6812, 16'h0005, 16'h0003, 16'h0028, 16'h0003, 4'd3}, // shl
    '{8'h08, 16'h5982, 16'h0028, 16'h0003, 16'h0005, 16'h0003, 4'd3}, // shr
    '{8'h09, 16'h8A6C, 16'h0007, 16'h0000, 16'h0004, 16'h000C, 4'd4}, // andi
    '{8'h0A, 16'h9B1A, 16'h0005, 16'h0004, 16'h000F, 16'h000A, 4'd4}, // ori
    '{8'h0B, 16'hAC1F, 16'h0005, 16'h0000, 16'h0014, 16'h000F, 4'd4}, // addi
    '{8'h0C, 16'h7DFF, 16'h0000, 16'h0000, 16'h00FF, 16'h00FF, 4'd4}, // ldi 0xff
    '{8'h0D, 16'hB019, 16'h0005, 16'h0005, 16'h0000, 16'h0005, 4'd6}, // R6 cmp equal
    '{8'h0E, 16'h1E11, 16'h0005, 16'h0005, 16'h0005, 16'h0005, 4'd6}, // or keeps flag
    '{8'h0F, 16'hF003, 16'h0000, 16'h0008, 16'h0000, 16'h0003, 4'd8}, // R8 beq taken
    '{8'h12, 16'hB091, 16'h0005, 16'h0005, 16'h0000, 16'h0005, 4'd6}, // cmp equal
    '{8'h13, 16'hE005, 16'h0000, 16'h0001, 16'h0000, 16'h0005, 4'd8}, // bne not taken
    '{8'h14, 16'hD040, 16'h0002, 16'h0000, 16'h0000, 16'h0040, 4'd7}, // R7 jump
    '{8'h40, 16'hA001, 16'h0000, 16'h0005, 16'h0001, 16'h0001, 4'd4}, // addi r0
    '{8'h41, 16'hE0F0, 16'h0000, 16'h0001, 16'h0000, 16'h00F0, 4'd8}, // bne taken, wraps
    '{8'h31, 16'hC000, 16'h0001, 16'h0001, 16'h0000, 16'h0001, 4'd9}, // R9 nop
    '{8'h32, 16'hB0DE, 16'h00FF, 16'h0005, 16'h00FA, 16'h0005, 4'd5}, // R5 read back
    '{8'h33, 16'hB0F0, 16'h0000, 16'h0001, 16'hFFFF, 16'h0001, 4'd5}, // r15 never written
    '{8'h34, 16'hB0AB, 16'h0004, 16'h000F, 16'hFFF5, 16'h000F, 4'd5},
    '{8'h35, 16'hB0C7, 16'h0014, 16'h0006, 16'h000E, 16'h0006, 4'd5},
    '{8'h36, 16'hD036, 16'h0008, 16'h0007, 16'h0000, 16'h0036, 4'd7}, // self loop
    '{8'h36, 16'hD036, 16'h0008, 16'h0007, 16'h0000, 16'h0036, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr;
  logic [15:0] imem_data;
  logic [15:0] d_instr, d_a, d_b, d_alu, d_opb;
  logic [7:0]  d_pc;
  logic [15:0] imem [256];

  int n_chk = 0;
  int n_bad = 0;

  assign imem_data = imem[imem_addr];

  always #(PERIOD/2) clk = ~clk;

  cpu16_core uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .imem_addr_o (imem_addr),
    .imem_data_i (imem_data),
    .dbg_instr_o (d_instr),
    .dbg_rd_a_o  (d_a),
    .dbg_rd_b_o  (d_b),
    .dbg_alu_o   (d_alu),
    .dbg_pc_o    (d_pc),
    .dbg_op_b_o  (d_opb)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(PERIOD*2000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) imem[i] = 16'hC000;
    for (int i = 0; i < NSTEP; i++) imem[STEPS[i].pc] = STEPS[i].ins;
    imem[8'h10] = 16'h7FEE;  // skipped by the taken branch
    imem[8'h11] = 16'h7FEE;

    repeat (2) @(negedge clk);
    #1;
    chk("R1", "pc in reset", {8'h00, d_pc}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    for (int i = 0; i < NSTEP; i++) begin
      chk("R8", $sformatf("pc step %0d", i), {8'h00, d_pc}, {8'h00, STEPS[i].pc});
      chk("R2", $sformatf("instr step %0d", i), d_instr, STEPS[i].ins);
      chk("R2", $sformatf("rd_a step %0d", i), d_a, STEPS[i].a);
      chk("R2", $sformatf("rd_b step %0d", i), d_b, STEPS[i].b);
      chk($sformatf("R%0d", STEPS[i].tag), $sformatf("alu step %0d", i), d_alu, STEPS[i].alu);
      chk("R4", $sformatf("op_b step %0d", i), d_opb, STEPS[i].opb);
      @(negedge clk);
      #1;
    end

    // R1: set flag, then reset mid-run and confirm regs and flag cleared
    imem[8'h36] = 16'hB000;  // cmp r0,r0 -> flag 1
    imem[8'h00] = 16'hF002;  // beq +2 at address 0
    @(negedge clk);
    #1;
    chk("R8", "pc after cmp", {8'h00, d_pc}, 16'h0037);
    rst_n = 1'b0;
    #1;
    chk("R1", "pc async clear", {8'h00, d_pc}, 16'h0000);
    chk("R1", "r0 cleared", d_a, 16'h0000);
    chk("R1", "r2 cleared", d_b, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "flag cleared, beq not taken", {8'h00, d_pc}, 16'h0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule